// File: doc/BRIEF.md
# Receiver Termination Detect Controller

This block sequences far-end receiver detection for a multi-lane linear redriver whose lanes are split into independent groups (two groups of four lanes by default). For each group it issues one-cycle detection requests to an analog comparator, counts consecutive successful results and, once the count reaches the number the selected mode requires, switches the group's input termination from high impedance to 50 ohm and latches that state. The analog detect circuit and the multi-level pin decoder sit outside; the block takes an already decoded mode code.

Each group has its own power-down input. While it is high the group's termination is high impedance and no requests are issued; the other group keeps running. A power-down held for at least a programmable number of cycles and then released throws away the group's detection progress and starts a fresh sequence. A shorter pulse leaves no lasting trace. The clock is the time base: the poll interval and the hold threshold are cycle-count parameters (150 us and 200 us at 250 MHz by default, shortened in simulation).

Top module: `rx_term_detect`

## Requirements
- R1: Mode code 0 disables detection: with its power-down low, each group shows termOn=1 (50 ohm), detected=0, and issues no attempt strobe.
- R2: Mode code 1 requires three consecutive hits: a group sets detected and termOn after its third consecutive hit; a miss (cmpHit=0 in the sample cycle) resets the run to zero.
- R3: Mode code 2 behaves as mode 1 but two consecutive hits are enough.
- R4: Mode code 4 polls until one hit, then latches detected and termOn.
- R5: Codes 3, 5, 6 and 7 behave as mode 0 and raise rsvdMode=1, except that rsvdMode is 0 whenever every power-down input is high.
- R6: attempt is a one-cycle strobe; cmpHit of a group is taken only in the cycle right after that group's strobe and has no effect in any other cycle; detected changes at the earliest two cycles after the strobe.
- R7: While a group is undetected in an active mode and its power-down stays low, consecutive strobes are exactly POLL_CYCLES+2 cycles apart.
- R8: Once detected, a group issues no further strobes and keeps detected=1 and termOn=1 until a qualified power-down release.
- R9: A group whose power-down input is high shows termOn=0 and issues no strobe, while the other group's behaviour is unaffected.
- R10: A power-down pulse of at least PD_HOLD_CYCLES cycles clears detected on release and the group restarts detection; a shorter pulse leaves detected unchanged.
- R11: After reset every group shows attempt=0 and detected=0, and termOn=0 in an active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the time base for poll and hold counts |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Decoded mode code (0 off, 1 three hits, 2 two hits, 3 reserved, 4 single hit, 5-7 reserved) |
| pdIn | input | NUM_GROUPS | Per-group power-down / reset request, high active |
| cmpHit | input | NUM_GROUPS | Per-group comparator result, valid in the cycle after attempt |
| attempt | output | NUM_GROUPS | Per-group one-cycle detection request |
| termOn | output | NUM_GROUPS | Per-group termination select: 1 = 50 ohm, 0 = high impedance |
| detected | output | NUM_GROUPS | Per-group latched detection status |
| rsvdMode | output | 1 | Reserved mode code in use |

## Verification
The hardest states to reach from the ports are a miss landing in the middle of a qualification run and a power-down released exactly at, or one cycle short of, the hold threshold while the other group is mid-sequence. The stimulus keys comparator results off each observed strobe, using per-group scripted hit/miss patterns for the directed runs and weighted random results afterwards, and it draws power-down lengths from a window straddling the threshold. A cycle-level model in the bench predicts termination, detection and strobe spacing for both groups throughout.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_PULSE,
    ST_SAMPLE,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic loadTimer;
    logic incHits;
    logic clrHits;
    logic setDet;
    logic clrDet;
  } dpCmd_t;

  // Number of consecutive hits a mode needs; zero means detection is off.
  function automatic logic [1:0] hitsForMode(input logic [2:0] code);
    case (code)
      3'd1:    hitsForMode = 2'd3;
      3'd2:    hitsForMode = 2'd2;
      3'd4:    hitsForMode = 2'd1;
      default: hitsForMode = 2'd0;
    endcase
  endfunction

  function automatic logic isReservedCode(input logic [2:0] code);
    isReservedCode = (code == 3'd3) || (code > 3'd4);
  endfunction

endpackage

// File: rtl/rtd_pd_qual.sv
module rtd_pd_qual #(
  parameter int HOLD_CYCLES = 50000
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdIn,
  output logic rearm
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYCLES);

  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!pdIn) begin
      holdCnt <= '0;
    end else if (holdCnt != FULL) begin
      holdCnt <= holdCnt + CW'(1);
    end
  end

  // Release after a long enough hold restarts the group.
  assign rearm = !pdIn && (holdCnt == FULL);

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= FULL);

  p_rearm_qualified_r10: assert property (@(posedge clk) disable iff (!rstN)
    rearm |-> $past(pdIn));

endmodule

// File: rtl/rtd_seq_dp.sv
module rtd_seq_dp
  import rtd_pkg::*;
#(
  parameter int POLL_CYCLES = 37500
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  output logic       timerZero,
  output logic [1:0] hitCnt,
  output logic       detFlag
);
  localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(POLL_CYCLES - 1);

  logic [TW-1:0] pollTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollTimer <= '0;
    end else if (cmd.loadTimer) begin
      pollTimer <= RELOAD;
    end else if (pollTimer != '0) begin
      pollTimer <= pollTimer - TW'(1);
    end
  end

  assign timerZero = (pollTimer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCnt <= '0;
    end else if (cmd.clrHits) begin
      hitCnt <= '0;
    end else if (cmd.incHits && hitCnt != 2'd3) begin
      hitCnt <= hitCnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detFlag <= 1'b0;
    end else if (cmd.clrDet) begin
      detFlag <= 1'b0;
    end else if (cmd.setDet) begin
      detFlag <= 1'b1;
    end
  end

  p_cmd_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.setDet && cmd.clrDet) && !(cmd.incHits && cmd.clrHits));

  p_hit_counted_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incHits && !cmd.clrHits) |=> hitCnt != 2'd0);

endmodule

// File: rtl/rtd_seq_ctrl.sv
module rtd_seq_ctrl
  import rtd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       detActive,
  input  logic [1:0] needHits,
  input  logic       pdIn,
  input  logic       rearm,
  input  logic       cmpHit,
  input  logic       timerZero,
  input  logic [1:0] hitCnt,
  input  logic       detFlag,
  output dpCmd_t     cmd,
  output logic       attempt
);
  seqState_t state, nxtState;
  logic [2:0] hitsAfter;

  assign hitsAfter = {1'b0, hitCnt} + 3'd1;

  always_comb begin
    nxtState = state;
    cmd      = '0;
    if (rearm) begin
      // Qualified release: discard all progress.
      cmd.clrHits   = 1'b1;
      cmd.clrDet    = 1'b1;
      cmd.loadTimer = 1'b1;
      nxtState      = ST_WAIT;
    end else if (pdIn) begin
      // Held in reset: abort any attempt, keep counts and latch.
      if (state == ST_WAIT || state == ST_PULSE || state == ST_SAMPLE) begin
        cmd.loadTimer = 1'b1;
        nxtState      = ST_WAIT;
      end
    end else if (!detActive) begin
      cmd.clrHits = 1'b1;
      cmd.clrDet  = 1'b1;
      nxtState    = ST_OFF;
    end else begin
      case (state)
        ST_OFF: begin
          cmd.clrHits   = 1'b1;
          cmd.loadTimer = 1'b1;
          nxtState      = ST_WAIT;
        end
        ST_WAIT: begin
          if (timerZero) nxtState = ST_PULSE;
        end
        ST_PULSE: begin
          nxtState = ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (cmpHit) begin
            cmd.incHits = 1'b1;
            if (hitsAfter >= {1'b0, needHits}) begin
              cmd.setDet = 1'b1;
              nxtState   = ST_DONE;
            end else begin
              cmd.loadTimer = 1'b1;
              nxtState      = ST_WAIT;
            end
          end else begin
            cmd.clrHits   = 1'b1;
            cmd.loadTimer = 1'b1;
            nxtState      = ST_WAIT;
          end
        end
        ST_DONE: begin
          nxtState = ST_DONE;
        end
        default: begin
          nxtState = ST_OFF;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxtState;
  end

  assign attempt = (state == ST_PULSE) && !pdIn;

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    attempt |=> !attempt);

  p_det_after_attempt_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detFlag) |-> $past(attempt, 2));

  p_poll_due_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(attempt) |-> $past(timerZero));

  p_miss_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAMPLE && !pdIn && !rearm && detActive && !cmpHit) |=> hitCnt == 2'd0);

  p_det_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (detFlag && !rearm && (detActive || pdIn)) |=> detFlag);

  p_no_strobe_when_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    detFlag |-> !attempt);

endmodule

// File: rtl/rx_term_detect.sv
module rx_term_detect
  import rtd_pkg::*;
#(
  parameter int NUM_GROUPS     = 2,
  parameter int POLL_CYCLES    = 37500,
  parameter int PD_HOLD_CYCLES = 50000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            modeSel,
  input  logic [NUM_GROUPS-1:0] pdIn,
  input  logic [NUM_GROUPS-1:0] cmpHit,
  output logic [NUM_GROUPS-1:0] attempt,
  output logic [NUM_GROUPS-1:0] termOn,
  output logic [NUM_GROUPS-1:0] detected,
  output logic                  rsvdMode
);
  logic [1:0] needHits;
  logic       detActive;

  assign needHits  = hitsForMode(modeSel);
  assign detActive = (needHits != 2'd0);
  assign rsvdMode  = isReservedCode(modeSel) && !(&pdIn);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic       rearm;
    logic       timerZero;
    logic [1:0] hitCnt;
    logic       detFlag;
    dpCmd_t     cmd;

    rtd_pd_qual #(
      .HOLD_CYCLES(PD_HOLD_CYCLES)
    ) i_qual (
      .clk  (clk),
      .rstN (rstN),
      .pdIn (pdIn[g]),
      .rearm(rearm)
    );

    rtd_seq_ctrl i_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .detActive(detActive),
      .needHits (needHits),
      .pdIn     (pdIn[g]),
      .rearm    (rearm),
      .cmpHit   (cmpHit[g]),
      .timerZero(timerZero),
      .hitCnt   (hitCnt),
      .detFlag  (detFlag),
      .cmd      (cmd),
      .attempt  (attempt[g])
    );

    rtd_seq_dp #(
      .POLL_CYCLES(POLL_CYCLES)
    ) i_dp (
      .clk      (clk),
      .rstN     (rstN),
      .cmd      (cmd),
      .timerZero(timerZero),
      .hitCnt   (hitCnt),
      .detFlag  (detFlag)
    );

    assign termOn[g]   = !pdIn[g] && (!detActive || detFlag);
    assign detected[g] = detFlag;

    p_term_follows_det_r8: assert property (@(posedge clk) disable iff (!rstN)
      (detected[g] && !pdIn[g]) |-> termOn[g]);
  end

endmodule

// File: tb/test_rx_term_detect.sv
module test_rx_term_detect;
  localparam int NG   = 2;
  localparam int POLL = 12;
  localparam int HOLD = 10;
  localparam int GAP  = POLL + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    modeSel;
  logic [NG-1:0] pdIn;
  logic [NG-1:0] cmpHit;
  logic [NG-1:0] attempt;
  logic [NG-1:0] termOn;
  logic [NG-1:0] detected;
  logic          rsvdMode;

  always #2 clk = ~clk;

  rx_term_detect #(
    .NUM_GROUPS    (NG),
    .POLL_CYCLES   (POLL),
    .PD_HOLD_CYCLES(HOLD)
  ) i_rx_term_detect (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .pdIn    (pdIn),
    .cmpHit  (cmpHit),
    .attempt (attempt),
    .termOn  (termOn),
    .detected(detected),
    .rsvdMode(rsvdMode)
  );

  int nCmp = 0;
  int nBad = 0;
  int cyc  = 0;

  int          mHits[NG];
  bit          mDet[NG];
  bit          st1[NG], st2[NG], plan1[NG], plan2[NG];
  int          heldCnt[NG];
  bit          pdReq[NG];
  int          lastAtt[NG];
  int          hitPct[NG];
  int          nAtt[NG];
  logic [15:0] script[NG];
  int          scriptLen[NG];

  function automatic int needFor(input logic [2:0] m);
    case (m)
      3'd1:    return 3;
      3'd2:    return 2;
      3'd4:    return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit rsvdCode(input logic [2:0] m);
    return (m == 3'd3) || (m > 3'd4);
  endfunction

  function automatic bit expTerm(input int g);
    if (pdIn[g]) return 1'b0;
    if (needFor(modeSel) == 0) return 1'b1;
    return mDet[g];
  endfunction

  function automatic string termReq(input int g);
    if (pdIn[g]) return "R9";
    if (needFor(modeSel) == 0) return "R1/R5";
    return "R2/R3/R4";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic pickPlan(input int g, output bit res);
    if (scriptLen[g] > 0) begin
      res = script[g][0];
      script[g] = script[g] >> 1;
      scriptLen[g]--;
    end else begin
      res = (($urandom % 100) < hitPct[g]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int g = 0; g < NG; g++) begin
      if (st2[g]) begin
        mHits[g] = plan2[g] ? mHits[g] + 1 : 0;
        if (needFor(modeSel) != 0 && mHits[g] >= needFor(modeSel)) mDet[g] = 1'b1;
      end
      st2[g]   = st1[g];
      plan2[g] = plan1[g];
      st1[g]   = 1'b0;
      if (pdIn[g]) begin
        heldCnt[g]++;
        lastAtt[g] = -1;
      end

      check(termOn[g] == expTerm(g), termReq(g), $sformatf("termOn[%0d]", g),
            int'(termOn[g]), int'(expTerm(g)));
      check(detected[g] == mDet[g], "R6/R8", $sformatf("detected[%0d]", g),
            int'(detected[g]), int'(mDet[g]));

      if (pdIn[g] || needFor(modeSel) == 0 || mDet[g]) begin
        check(attempt[g] == 1'b0, "R8/R9/R1", $sformatf("attempt[%0d] not allowed", g),
              int'(attempt[g]), 0);
      end else if (attempt[g]) begin
        if (lastAtt[g] >= 0)
          check(cyc - lastAtt[g] == GAP, "R7", $sformatf("strobe spacing[%0d]", g),
                cyc - lastAtt[g], GAP);
        lastAtt[g] = cyc;
        st1[g]     = 1'b1;
        pickPlan(g, plan1[g]);
        nAtt[g]++;
      end
    end
    check(rsvdMode == (rsvdCode(modeSel) && !(&pdIn)), "R5", "rsvdMode",
          int'(rsvdMode), int'(rsvdCode(modeSel) && !(&pdIn)));

    for (int g = 0; g < NG; g++) begin
      if (st1[g])      cmpHit[g] = plan1[g];
      else if (st2[g]) cmpHit[g] = plan2[g];
      else             cmpHit[g] = 1'($urandom % 2);
      if (pdReq[g] != pdIn[g] && !st1[g] && !st2[g]) begin
        if (pdReq[g]) begin
          heldCnt[g] = 0;
        end else begin
          if (heldCnt[g] >= HOLD) begin
            mHits[g] = 0;
            mDet[g]  = 1'b0;
          end
          heldCnt[g] = 0;
          lastAtt[g] = -1;
        end
        pdIn[g] = pdReq[g];
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic setMode(input logic [2:0] m);
    for (int g = 0; g < NG; g++) pdReq[g] = 1'b1;
    while (!(&pdIn)) step();
    while (heldCnt[0] < HOLD + 1 || heldCnt[1] < HOLD + 1) step();
    modeSel = m;
    step();
    for (int g = 0; g < NG; g++) begin
      pdReq[g]     = 1'b0;
      scriptLen[g] = 0;
      hitPct[g]    = 100;
      nAtt[g]      = 0;
    end
    while (|pdIn) step();
    step();
  endtask

  task automatic pulsePd(input int g, input int len);
    pdReq[g] = 1'b1;
    while (!pdIn[g]) step();
    while (heldCnt[g] < len - 1) step();
    pdReq[g] = 1'b0;
    while (pdIn[g]) step();
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int base0, base1;
    logic [2:0] modeList [10];
    void'($urandom(32'h2f1d));
    modeList = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd1, 3'd2, 3'd4, 3'd3, 3'd5, 3'd7};
    for (int g = 0; g < NG; g++) begin
      mHits[g] = 0; mDet[g] = 0; st1[g] = 0; st2[g] = 0; plan1[g] = 0; plan2[g] = 0;
      heldCnt[g] = 0; pdReq[g] = 0; lastAtt[g] = -1; hitPct[g] = 100; nAtt[g] = 0;
      script[g] = '0; scriptLen[g] = 0;
    end
    modeSel = 3'd1;
    pdIn    = '0;
    cmpHit  = '0;
    // Group 0: hit, hit, miss, hit, hit, hit (LSB first)
    script[0] = 16'b111011; scriptLen[0] = 6;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    check(attempt == '0, "R11", "attempt after reset", int'(attempt), 0);
    check(detected == '0, "R11", "detected after reset", int'(detected), 0);
    check(termOn == '0, "R11", "termOn after reset", int'(termOn), 0);

    // Mode 1: three consecutive hits, miss restarts the run
    run(7 * GAP + 4);
    check(detected[0] == 1'b1, "R2", "group0 detected after scripted run", int'(detected[0]), 1);
    check(nAtt[0] == 6, "R2", "group0 strobes incl. miss restart", nAtt[0], 6);
    check(nAtt[1] == 3, "R2", "group1 strobes to three hits", nAtt[1], 3);
    base0 = nAtt[0]; base1 = nAtt[1];
    run(3 * GAP);
    check(nAtt[0] == base0 && nAtt[1] == base1, "R8", "no strobes once detected",
          nAtt[0] + nAtt[1], base0 + base1);

    // Short power-down pulse has no lasting effect
    pulsePd(0, HOLD - 1);
    run(3);
    check(detected[0] == 1'b1, "R10", "short pulse keeps detection", int'(detected[0]), 1);
    check(termOn[0] == 1'b1, "R10", "short pulse keeps 50 ohm", int'(termOn[0]), 1);

    // Qualified pulse on group 0 while group 1 sits in power-down
    pdReq[1] = 1'b1;
    pulsePd(0, HOLD);
    run(1);
    check(detected[0] == 1'b0, "R10", "qualified pulse clears detection", int'(detected[0]), 0);
    base0 = nAtt[0];
    run(4 * GAP);
    check(detected[0] == 1'b1, "R9", "group0 redetects beside held group1", int'(detected[0]), 1);
    check(nAtt[0] - base0 == 3, "R2", "three strobes after restart", nAtt[0] - base0, 3);
    check(termOn[1] == 1'b0, "R9", "held group1 high impedance", int'(termOn[1]), 0);
    pdReq[1] = 1'b0;
    run(2);
    check(detected[1] == 1'b0, "R10", "group1 cleared by long hold", int'(detected[1]), 0);
    run(4 * GAP);
    check(detected[1] == 1'b1, "R2", "group1 redetects", int'(detected[1]), 1);

    // Mode 2: two consecutive hits
    setMode(3'd2);
    script[0] = 16'b1101; scriptLen[0] = 4;
    script[1] = 16'b1100; scriptLen[1] = 4;
    run(5 * GAP + 4);
    check(detected == 2'b11, "R3", "both groups detected in mode 2", int'(detected), 3);
    check(nAtt[0] == 4, "R3", "group0 strobes in mode 2", nAtt[0], 4);
    check(nAtt[1] == 4, "R3", "group1 strobes in mode 2", nAtt[1], 4);

    // Mode 4: single hit, steady polling until then
    setMode(3'd4);
    script[0] = 16'b1000; scriptLen[0] = 4;
    hitPct[1] = 0;
    run(5 * GAP + 4);
    check(detected[0] == 1'b1, "R4", "group0 detected on first hit", int'(detected[0]), 1);
    check(nAtt[0] == 4, "R4", "group0 strobes in mode 4", nAtt[0], 4);
    check(detected[1] == 1'b0, "R4", "group1 still polling", int'(detected[1]), 0);
    check(nAtt[1] >= 5, "R7", "group1 keeps polling", nAtt[1], 5);
    hitPct[1] = 100;
    run(2 * GAP + 2);
    check(detected[1] == 1'b1, "R4", "group1 detected after hit", int'(detected[1]), 1);

    // Mode 0: detection off
    setMode(3'd0);
    run(40);
    check(termOn == 2'b11, "R1", "mode 0 termination", int'(termOn), 3);
    check(nAtt[0] + nAtt[1] == 0, "R1", "mode 0 strobes", nAtt[0] + nAtt[1], 0);
    check(rsvdMode == 1'b0, "R1", "mode 0 not reserved", int'(rsvdMode), 0);

    // Reserved codes
    setMode(3'd3);
    run(5);
    check(rsvdMode == 1'b1, "R5", "code 3 flagged", int'(rsvdMode), 1);
    check(termOn == 2'b11, "R5", "code 3 termination", int'(termOn), 3);
    pdReq[0] = 1'b1; pdReq[1] = 1'b1;
    run(3);
    check(rsvdMode == 1'b0, "R5", "flag masked with all groups down", int'(rsvdMode), 0);
    check(termOn == 2'b00, "R9", "all groups down high impedance", int'(termOn), 0);
    pdReq[0] = 1'b0; pdReq[1] = 1'b0;
    run(2);
    setMode(3'd6);
    run(3);
    check(rsvdMode == 1'b1, "R5", "code 6 flagged", int'(rsvdMode), 1);

    // Random phases around the hold threshold
    for (int it = 0; it < 30; it++) begin
      setMode(modeList[$urandom % 10]);
      for (int g = 0; g < NG; g++) hitPct[g] = $urandom % 101;
      for (int k = 0; k < 6; k++) begin
        run(10 + ($urandom % 60));
        if (($urandom % 3) == 0) pulsePd(int'($urandom % NG), HOLD - 2 + int'($urandom % 4));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule